// File: doc/BRIEF.md
# Edge Detector with Initial-State Reset

This block watches one digital signal and raises a registered flag for exactly one clock when the signal changes in the chosen direction. A sequential control loop evaluates it once per clock. It compares the current signal against a stored prior value. The caller can re-seed that stored value at any time with a re-arm request. An initial-state input supplies the value to assume for the signal's previous sample.

A re-arm request can come from a level input or a pulse input. The level input counts only on its low-to-high change. The pulse input counts on every cycle it is high, so back-to-back re-arms need no falling edge between them. A reload-select input chooses whether a re-arm loads the stored value from the initial-state input or leaves it as it is. The first evaluation after power-up always re-arms from the initial-state input. A disabled detector stays silent and holds its stored value. A re-arm taken while disabled still sets the reference for the next enabled cycle. The edge direction is fixed by a parameter.

Top module: `edge_watch`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled high, `hit_o` is 0.
- R2: With EDGE = EDGE_RISE, an enabled evaluation where the reference is 0 and `sig_in` is 1 makes `hit_o` 1 on the following cycle. Any other combination gives 0.
- R3: With EDGE = EDGE_FALL, an enabled evaluation where the reference is 1 and `sig_in` is 0 makes `hit_o` 1 on the following cycle. Any other combination gives 0.
- R4: With EDGE = EDGE_ANY, an enabled evaluation where the reference and `sig_in` differ makes `hit_o` 1 on the following cycle.
- R5: `hit_o` is registered. It appears one clock after the evaluating edge and lasts one clock, unless the next evaluation also detects. An enabled evaluation stores `sig_in` as the new prior value.
- R6: The first evaluation after reset uses `init_val_in` as the reference, whatever `reload_sel_in` is. A detect is possible on that very evaluation.
- R7: `rearm_in` causes a re-arm only on a cycle where it is 1 and it was 0 at the previous evaluation. Holding it high does not re-arm again.
- R8: Every evaluation with `rearm_pulse_in` high is a re-arm, including consecutive cycles.
- R9: A re-arm with `reload_sel_in` = 0 keeps the stored prior value. A re-arm with `reload_sel_in` = 1 replaces it with `init_val_in`.
- R10: On a re-arm cycle that reloads, the same evaluation compares `sig_in` against the newly loaded `init_val_in`.
- R11: When `en_in` is 0, `hit_o` is 0 on the next cycle. The stored prior value is unchanged unless a reloading re-arm occurs.
- R12: A reloading re-arm taken while `en_in` is 0 sets the reference used by the next enabled evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sig_in | input | 1 | Watched signal |
| en_in | input | 1 | Evaluation enable |
| rearm_in | input | 1 | Level re-arm request, acts on its rising change |
| rearm_pulse_in | input | 1 | Pulse re-arm request, acts on each high cycle |
| init_val_in | input | 1 | Assumed previous value of the signal |
| reload_sel_in | input | 1 | 1: a re-arm loads the prior value from init_val_in |
| hit_o | output | 1 | One-cycle registered edge flag |

## Verification
The bench builds three copies of the block side by side, one for each EDGE value: EDGE_RISE, EDGE_FALL and EDGE_ANY. All three are driven from the same inputs. Every direction rule is checked against the same histories of re-arms, enables and reloads. Directed steps cover the first-evaluation detect, same-cycle detect on re-arm, a held level versus consecutive pulses, and re-arm while disabled. Random steps then mix all inputs.

// File: rtl/edge_watch_pkg.sv
package edge_watch_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_kind_t;
endpackage

// File: rtl/rearm_gen.sv
module rearm_gen (
  input  logic clk,
  input  logic rst,
  input  logic rearm_in,
  input  logic rearm_pulse_in,
  output logic first_o,
  output logic evt_o
);
  logic first_q;
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      level_q <= 1'b0;
    end else begin
      first_q <= 1'b0;
      level_q <= rearm_in;
    end
  end

  assign first_o = first_q;
  assign evt_o   = first_q | (rearm_in & ~level_q) | rearm_pulse_in;

  // R7: a level held high across evaluations gives no fresh re-arm
  a_r7_level_once: assert property (@(posedge clk) disable iff (rst)
    (rearm_in && !first_q && !rearm_pulse_in) |=> (!(rearm_in && !rearm_pulse_in) || !evt_o));
  // R8: pulse input always re-arms
  a_r8_pulse_rearms: assert property (@(posedge clk) disable iff (rst)
    rearm_pulse_in |-> evt_o);
endmodule

// File: rtl/prior_store.sv
module prior_store (
  input  logic clk,
  input  logic rst,
  input  logic first_i,
  input  logic evt_i,
  input  logic reload_sel_i,
  input  logic init_val_i,
  input  logic en_i,
  input  logic sig_i,
  output logic ref_o
);
  logic prior_q;
  logic load_init;

  assign load_init = first_i | (evt_i & reload_sel_i);
  assign ref_o     = load_init ? init_val_i : prior_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prior_q <= 1'b0;
    end else if (en_i) begin
      prior_q <= sig_i;
    end else begin
      prior_q <= ref_o;
    end
  end

  // R6: first evaluation compares against the initial value
  a_r6_first_uses_init: assert property (@(posedge clk) disable iff (rst)
    first_i |-> (ref_o == init_val_i));
  // R11: disabled with no reloading re-arm keeps the stored value
  a_r11_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !first_i && !(evt_i && reload_sel_i)) |=> $stable(prior_q));
  // R5: an enabled evaluation stores the signal
  a_r5_stores_sig: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (prior_q == $past(sig_i)));
endmodule

// File: rtl/edge_cmp.sv
module edge_cmp
  import edge_watch_pkg::*;
#(
  parameter edge_kind_t EDGE = EDGE_RISE
) (
  input  logic ref_i,
  input  logic sig_i,
  input  logic en_i,
  output logic hit_o
);
  logic raw;

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      assign raw = ~ref_i & sig_i;
    end else if (EDGE == EDGE_FALL) begin : g_fall
      assign raw = ref_i & ~sig_i;
    end else begin : g_any
      assign raw = ref_i ^ sig_i;
    end
  endgenerate

  assign hit_o = en_i & raw;
endmodule

// File: rtl/edge_watch.sv
module edge_watch
  import edge_watch_pkg::*;
#(
  parameter edge_kind_t EDGE = EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  input  logic en_in,
  input  logic rearm_in,
  input  logic rearm_pulse_in,
  input  logic init_val_in,
  input  logic reload_sel_in,
  output logic hit_o
);
  logic first_w;
  logic evt_w;
  logic ref_w;
  logic hit_d;
  logic hit_q;

  rearm_gen u_rearm (
    .clk            (clk),
    .rst            (rst),
    .rearm_in       (rearm_in),
    .rearm_pulse_in (rearm_pulse_in),
    .first_o        (first_w),
    .evt_o          (evt_w)
  );

  prior_store u_prior (
    .clk          (clk),
    .rst          (rst),
    .first_i      (first_w),
    .evt_i        (evt_w),
    .reload_sel_i (reload_sel_in),
    .init_val_i   (init_val_in),
    .en_i         (en_in),
    .sig_i        (sig_in),
    .ref_o        (ref_w)
  );

  edge_cmp #(.EDGE(EDGE)) u_cmp (
    .ref_i (ref_w),
    .sig_i (sig_in),
    .en_i  (en_in),
    .hit_o (hit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_d;
  end

  assign hit_o = hit_q;

  // R11: disabled evaluation never flags
  a_r11_off_silent: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> !hit_o);
  // R2: rising mode flags only when the signal was high
  a_r2_rise_sig_high: assert property (@(posedge clk) disable iff (rst)
    (EDGE == EDGE_RISE && hit_o) |-> $past(sig_in));
  // R3: falling mode flags only when the signal was low
  a_r3_fall_sig_low: assert property (@(posedge clk) disable iff (rst)
    (EDGE == EDGE_FALL && hit_o) |-> !$past(sig_in));
  // R10: a reloading re-arm compares against the initial value
  a_r10_rearm_ref: assert property (@(posedge clk) disable iff (rst)
    (evt_w && reload_sel_in) |-> (ref_w == init_val_in));
endmodule

// File: tb/edge_watch_bench.sv
module edge_watch_bench;
  import edge_watch_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s = 0, e = 0, rl = 0, rp = 0, iv = 0, sel = 0;
  logic h_r, h_f, h_a;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  edge_watch #(.EDGE(EDGE_RISE)) u_edge_watch (
    .clk(clk), .rst(rst), .sig_in(s), .en_in(e), .rearm_in(rl),
    .rearm_pulse_in(rp), .init_val_in(iv), .reload_sel_in(sel), .hit_o(h_r));
  edge_watch #(.EDGE(EDGE_FALL)) u_edge_watch_fall (
    .clk(clk), .rst(rst), .sig_in(s), .en_in(e), .rearm_in(rl),
    .rearm_pulse_in(rp), .init_val_in(iv), .reload_sel_in(sel), .hit_o(h_f));
  edge_watch #(.EDGE(EDGE_ANY)) u_edge_watch_any (
    .clk(clk), .rst(rst), .sig_in(s), .en_in(e), .rearm_in(rl),
    .rearm_pulse_in(rp), .init_val_in(iv), .reload_sel_in(sel), .hit_o(h_a));

  // reference model state
  bit m_first, m_lvl, m_prior;

  function automatic bit model_ref(bit rl_i, bit rp_i, bit iv_i, bit sel_i);
    bit evt;
    evt = m_first | (rl_i & ~m_lvl) | rp_i;
    return (m_first | (evt & sel_i)) ? iv_i : m_prior;
  endfunction

  task automatic check(input logic act, input bit exp, input string tag, input string who);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, who, act, exp);
    end
  endtask

  task automatic step(input bit s_i, e_i, rl_i, rp_i, iv_i, sel_i,
                      input string tr, input string tf, input string ta);
    bit rf, xr, xf, xa;
    s = s_i; e = e_i; rl = rl_i; rp = rp_i; iv = iv_i; sel = sel_i;
    rf = model_ref(rl_i, rp_i, iv_i, sel_i);
    xr = e_i & ~rf & s_i;
    xf = e_i & rf & ~s_i;
    xa = e_i & (rf ^ s_i);
    m_prior = e_i ? s_i : rf;
    m_lvl   = rl_i;
    m_first = 0;
    @(posedge clk);
    @(negedge clk);
    check(h_r, xr, tr, "rise");
    check(h_f, xf, tf, "fall");
    check(h_a, xa, ta, "any");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd4711);
    m_first = 1; m_lvl = 0; m_prior = 0;
    repeat (3) @(negedge clk);
    check(h_r, 1'b0, "R1", "rise");
    check(h_f, 1'b0, "R1", "fall");
    check(h_a, 1'b0, "R1", "any");
    rst = 1'b0;
    // R6: first evaluation against init (sel=0 still loads)
    step(1, 1, 0, 0, 0, 0, "R6", "R6", "R6");
    // R5: held signal, no repeat
    step(1, 1, 0, 0, 0, 0, "R5", "R5", "R5");
    // R3: falling edge
    step(0, 1, 0, 0, 0, 0, "R3", "R3", "R4");
    step(1, 1, 0, 0, 0, 0, "R2", "R3", "R4");
    // R10: level re-arm reloading init=0, same-cycle rise
    step(1, 1, 1, 0, 0, 1, "R10", "R10", "R10");
    // R7: held level, no second re-arm
    step(1, 1, 1, 0, 0, 1, "R7", "R7", "R7");
    // R8: back-to-back pulses
    step(1, 1, 1, 1, 0, 1, "R8", "R8", "R8");
    step(1, 1, 1, 1, 0, 1, "R8", "R8", "R8");
    // R9: re-arm without reload keeps prior
    step(1, 1, 0, 0, 0, 0, "R9", "R9", "R9");
    step(1, 1, 1, 0, 0, 0, "R9", "R9", "R9");
    step(1, 1, 0, 1, 0, 0, "R9", "R9", "R9");
    // R11: disabled toggling, frozen prior
    step(0, 0, 0, 0, 0, 0, "R11", "R11", "R11");
    step(1, 0, 0, 0, 0, 0, "R11", "R11", "R11");
    step(0, 0, 0, 0, 0, 0, "R11", "R11", "R11");
    step(1, 1, 0, 0, 0, 0, "R11", "R11", "R11");
    // R12: reload while disabled, then enabled rise
    step(1, 0, 0, 1, 0, 1, "R12", "R12", "R12");
    step(1, 0, 0, 0, 1, 0, "R12", "R12", "R12");
    step(1, 1, 0, 0, 1, 0, "R12", "R12", "R12");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 1), ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 7) == 0), $urandom_range(0, 1), $urandom_range(0, 1),
           "R2", "R3", "R4");
    end
    // R1: reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    s = 1; e = 1;
    @(negedge clk);
    check(h_r, 1'b0, "R1", "rise");
    check(h_a, 1'b0, "R1", "any");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule